// File: doc/BRIEF.md
# Channel Fault Qualifier and Diagnostic Encoder

This block sits between the raw fault detectors of a bank of low-side output switches and the diagnostic registers that a serial host reads. Each channel reports four raw fault kinds: short to supply, overtemperature, short to ground and open load. The block debounces each channel's fault with a cycle-count filter. It keeps the most recently confirmed fault as a 2-bit code and packs the codes of all channels into one vector, which the host reads out byte by byte.

Two sticky summary flags come with the codes. One records a confirmed overtemperature and the other records any confirmed fault. A single-cycle clear command from the serial side returns everything to the all-good state. When a short to supply is confirmed, the block either latches a per-channel switch-off or only reports the code. Some channels always switch off. Channels marked as selectable by a parameter take the choice from a configuration input. While the logic supply is under its threshold, no fault is stored.

Top module: `fault_latch_enc`

## Requirements
- R1: Channel n's code sits in `diag_o[2n+1:2n]`, so each byte carries four channels with the lowest channel in bits 1:0. The codes are 2'b11 for no fault, 2'b10 for short to supply or overtemperature, 2'b01 for open load and 2'b00 for short to ground.
- R2: A fault is stored only once the same fault kind has been sampled on FILT_CYCLES consecutive clock edges. A change of kind or a gap restarts the count.
- R3: A newly confirmed fault overwrites whatever code the channel held before.
- R4: A stored code and a shutdown latch persist after the raw fault disappears.
- R5: A clear (`clr_i` high at an edge) sets every code to 2'b11, drops both summary flags and releases all shutdown latches. Clear wins over a confirmation at the same edge. Clear does not restart the filters, so a fault that is still present and fully filtered is stored again at the next edge.
- R6: `fault_any_o` is set by any confirmed fault. `ot_any_o` is set only by a confirmed overtemperature. Both hold until clear or reset.
- R7: While `uv_i` is high nothing is stored and every filter is restarted.
- R8: On a channel whose bit in SCB_SELECTABLE is 0, a confirmed short to supply sets `chan_off_o[n]` whatever the value of `scb_off_cfg_i`. A confirmed overtemperature, open load or short to ground never sets it.
- R9: On a selectable channel, a confirmed short to supply sets `chan_off_o[n]` only when `scb_off_cfg_i[n]` is 1. With the bit at 0, only the code is set.
- R10: When several raw faults are present at once on a channel, the kind taken is the first present in this order: overtemperature, then short to supply, then short to ground, then open load.
- R11: Synchronous active-high reset gives all codes 2'b11, both flags 0 and all shutdown latches 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_i | input | 1 | Logic supply under threshold, blocks storage |
| clr_i | input | 1 | Clear diagnostics command, one cycle |
| raw_scb_i | input | NUM_CH | Raw short-to-supply indication per channel |
| raw_ot_i | input | NUM_CH | Raw overtemperature indication per channel |
| raw_scg_i | input | NUM_CH | Raw short-to-ground indication per channel |
| raw_ol_i | input | NUM_CH | Raw open-load indication per channel |
| scb_off_cfg_i | input | NUM_CH | 1: switch off on short to supply (selectable channels only) |
| diag_o | output | 2*NUM_CH | Packed 2-bit fault codes |
| ot_any_o | output | 1 | Sticky overtemperature summary |
| fault_any_o | output | 1 | Sticky any-fault summary |
| chan_off_o | output | NUM_CH | Latched per-channel switch-off |

## Verification
The bench drops a fault one edge short of the filter length and breaks a run by a single gap. An off-by-one or a counter that does not restart would then store a glitch. It overlaps a clear with a fault that is still held: a design that let the store win, or that restarted the filter on clear, would show the wrong code on the edge after the clear. Undervoltage is held during a fault and then removed, which catches storage under undervoltage and a filter that kept counting through it. Short to supply is also driven on fixed and on selectable channels with both configuration values, together with simultaneous faults, so that a swapped mask or a wrong priority order changes `chan_off_o` or the stored code.

// File: rtl/fle_pkg.sv
package fle_pkg;
  typedef enum logic [2:0] {
    FK_NONE = 3'd0,
    FK_SCB  = 3'd1,
    FK_OT   = 3'd2,
    FK_SCG  = 3'd3,
    FK_OL   = 3'd4
  } fault_kind_e;

  localparam logic [1:0] CODE_GOOD = 2'b11;

  function automatic logic [1:0] kind_code(input fault_kind_e k);
    case (k)
      FK_SCB, FK_OT: kind_code = 2'b10;
      FK_OL:         kind_code = 2'b01;
      FK_SCG:        kind_code = 2'b00;
      default:       kind_code = CODE_GOOD;
    endcase
  endfunction
endpackage

// File: rtl/fle_classify.sv
module fle_classify
  import fle_pkg::*;
(
  input  logic        scb_i,
  input  logic        ot_i,
  input  logic        scg_i,
  input  logic        ol_i,
  output fault_kind_e kind_o
);
  // fixed priority when several raw indications coincide
  always_comb begin
    if (ot_i)       kind_o = FK_OT;
    else if (scb_i) kind_o = FK_SCB;
    else if (scg_i) kind_o = FK_SCG;
    else if (ol_i)  kind_o = FK_OL;
    else            kind_o = FK_NONE;
  end
endmodule

// File: rtl/fle_filter.sv
module fle_filter
  import fle_pkg::*;
#(
  parameter int FILT_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        uv_i,
  input  fault_kind_e kind_i,
  output logic        confirm_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_CYCLES);

  logic [CW-1:0] cnt_q, cnt_nxt;
  fault_kind_e   prev_q;
  logic          active, same;

  assign active  = !uv_i && (kind_i != FK_NONE);
  assign same    = (kind_i == prev_q) && (cnt_q != '0);
  assign cnt_nxt = !same ? CW'(1) : ((cnt_q == FULL) ? FULL : cnt_q + CW'(1));
  assign confirm_o = active && (cnt_nxt == FULL);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q  <= '0;
      prev_q <= FK_NONE;
    end else begin
      cnt_q  <= cnt_nxt;
      prev_q <= kind_i;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL) else $error("filter count overflow"); // R2

  AST_UV_RESTART: assert property (@(posedge clk) disable iff (rst)
    uv_i |=> (cnt_q == '0)) else $error("filter ran under undervoltage"); // R7
endmodule

// File: rtl/fle_store.sv
module fle_store
  import fle_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr_i,
  input  logic        confirm_i,
  input  fault_kind_e kind_i,
  input  logic        shdn_en_i,
  output logic [1:0]  code_o,
  output logic        off_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      code_o <= CODE_GOOD;
      off_o  <= 1'b0;
    end else if (confirm_i) begin
      code_o <= kind_code(kind_i);
      if (kind_i == FK_SCB && shdn_en_i) off_o <= 1'b1;
    end
  end

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !confirm_i) |=> $stable(code_o)) else $error("code moved"); // R4

  AST_OFF_ON_SCB: assert property (@(posedge clk) disable iff (rst)
    $rose(off_o) |-> (code_o == 2'b10)) else $error("off without short"); // R8

  AST_CLEAR_CH: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (code_o == CODE_GOOD && !off_o)) else $error("clear missed"); // R5
endmodule

// File: rtl/fault_latch_enc.sv
module fault_latch_enc
  import fle_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int FILT_CYCLES = 4,
  parameter logic [NUM_CH-1:0] SCB_SELECTABLE = NUM_CH'(8'hC0)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  uv_i,
  input  logic                  clr_i,
  input  logic [NUM_CH-1:0]     raw_scb_i,
  input  logic [NUM_CH-1:0]     raw_ot_i,
  input  logic [NUM_CH-1:0]     raw_scg_i,
  input  logic [NUM_CH-1:0]     raw_ol_i,
  input  logic [NUM_CH-1:0]     scb_off_cfg_i,
  output logic [2*NUM_CH-1:0]   diag_o,
  output logic                  ot_any_o,
  output logic                  fault_any_o,
  output logic [NUM_CH-1:0]     chan_off_o
);
  logic [NUM_CH-1:0] confirm_w, ot_hit_w, shdn_en_w;
  fault_kind_e       kind_w [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    if (SCB_SELECTABLE[g]) begin : g_sel
      assign shdn_en_w[g] = scb_off_cfg_i[g];
    end else begin : g_fix
      assign shdn_en_w[g] = 1'b1;
    end

    fle_classify u_cls (
      .scb_i (raw_scb_i[g]),
      .ot_i  (raw_ot_i[g]),
      .scg_i (raw_scg_i[g]),
      .ol_i  (raw_ol_i[g]),
      .kind_o(kind_w[g])
    );

    fle_filter #(.FILT_CYCLES(FILT_CYCLES)) u_flt (
      .clk      (clk),
      .rst      (rst),
      .uv_i     (uv_i),
      .kind_i   (kind_w[g]),
      .confirm_o(confirm_w[g])
    );

    fle_store u_sto (
      .clk      (clk),
      .rst      (rst),
      .clr_i    (clr_i),
      .confirm_i(confirm_w[g]),
      .kind_i   (kind_w[g]),
      .shdn_en_i(shdn_en_w[g]),
      .code_o   (diag_o[2*g +: 2]),
      .off_o    (chan_off_o[g])
    );

    assign ot_hit_w[g] = confirm_w[g] && (kind_w[g] == FK_OT);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      ot_any_o    <= 1'b0;
      fault_any_o <= 1'b0;
    end else begin
      ot_any_o    <= ot_any_o | (|ot_hit_w);
      fault_any_o <= fault_any_o | (|confirm_w);
    end
  end

  AST_CLEAR_ALL_GOOD: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (&diag_o && !fault_any_o && !ot_any_o && chan_off_o == '0))
    else $error("clear incomplete"); // R5

  AST_UV_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (uv_i && !clr_i) |=> $stable(diag_o)) else $error("stored under uv"); // R7

  AST_ANY_COVERS: assert property (@(posedge clk) disable iff (rst)
    !(&diag_o) |-> fault_any_o) else $error("summary missing"); // R6

  AST_OT_IMPLIES_ANY: assert property (@(posedge clk) disable iff (rst)
    ot_any_o |-> fault_any_o) else $error("ot without any"); // R6
endmodule

// File: tb/tb_fault_latch_enc.sv
module tb_fault_latch_enc;
  localparam int N = 8;
  localparam int F = 4;
  localparam logic [N-1:0] MASK = 8'hC0;

  logic clk = 1'b0, rst = 1'b1, uv = 1'b0, clr = 1'b0;
  logic [N-1:0] scb = '0, ot = '0, scg = '0, ol = '0, cfg = '0;
  logic [2*N-1:0] diag;
  logic ot_any, f_any;
  logic [N-1:0] off;

  int checks = 0, errors = 0;
  bit started = 0;

  always #5 clk = ~clk;

  fault_latch_enc #(.NUM_CH(N), .FILT_CYCLES(F), .SCB_SELECTABLE(MASK)) dut (
    .clk(clk), .rst(rst), .uv_i(uv), .clr_i(clr),
    .raw_scb_i(scb), .raw_ot_i(ot), .raw_scg_i(scg), .raw_ol_i(ol),
    .scb_off_cfg_i(cfg), .diag_o(diag), .ot_any_o(ot_any),
    .fault_any_o(f_any), .chan_off_o(off)
  );

  // behavioural reference model
  int m_cnt [N];
  int m_prev[N];
  int m_code[N];
  bit m_off [N];
  bit m_ot, m_any;

  function automatic int kind_of(int c);
    if (ot[c]) return 2;
    if (scb[c]) return 1;
    if (scg[c]) return 3;
    if (ol[c]) return 4;
    return 0;
  endfunction

  function automatic int code_of(int k);
    if (k == 1 || k == 2) return 2;
    if (k == 4) return 1;
    if (k == 3) return 0;
    return 3;
  endfunction

  always @(posedge clk) begin
    bit hit_any, hit_ot;
    hit_any = 0; hit_ot = 0;
    started = 1;
    for (int c = 0; c < N; c++) begin
      int k, n;
      bit conf;
      k = kind_of(c); conf = 0;
      if (rst || uv || k == 0) begin
        m_cnt[c] = 0; m_prev[c] = 0;
      end else begin
        n = (k == m_prev[c] && m_cnt[c] > 0) ? m_cnt[c] + 1 : 1;
        if (n > F) n = F;
        m_cnt[c] = n; m_prev[c] = k;
        conf = (n >= F);
      end
      if (rst || clr) begin
        m_code[c] = 3; m_off[c] = 0;
      end else if (conf) begin
        m_code[c] = code_of(k);
        if (k == 1 && (!MASK[c] || cfg[c])) m_off[c] = 1;
        hit_any = 1;
        if (k == 2) hit_ot = 1;
      end
    end
    if (rst || clr) begin
      m_ot = 0; m_any = 0;
    end else begin
      m_ot = m_ot | hit_ot; m_any = m_any | hit_any;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      logic [2*N-1:0] e_diag;
      logic [N-1:0]   e_off;
      for (int c = 0; c < N; c++) begin
        e_diag[2*c +: 2] = 2'(m_code[c]);
        e_off[c] = m_off[c];
      end
      checks++;
      if (diag !== e_diag || off !== e_off || ot_any !== m_ot || f_any !== m_any) begin
        errors++;
        $display("FAIL R1 model: diag=%h off=%b ot=%b any=%b expected diag=%h off=%b ot=%b any=%b",
                 diag, off, ot_any, f_any, e_diag, e_off, m_ot, m_any);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] ch(input int c);
    return diag[2*c +: 2];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3); rst = 0;
    chk("R11 reset diag", 32'(diag), 32'hFFFF);
    chk("R11 reset flags", {30'd0, ot_any, f_any}, 0);
    chk("R11 reset off", 32'(off), 0);

    ol[2] = 1; tick(F-1);
    chk("R2 not yet stored", 32'(ch(2)), 3);
    tick(1);
    chk("R1 open load code", 32'(ch(2)), 1);
    chk("R6 any set ot clear", {30'd0, ot_any, f_any}, 1);

    ol[2] = 0; scg[0] = 1; tick(F-1);
    scg[0] = 0; tick(1);
    scg[0] = 1; tick(F-1);
    chk("R2 gap restarts filter", 32'(ch(0)), 3);
    chk("R4 code held after removal", 32'(ch(2)), 1);
    scg[0] = 0;

    scg[2] = 1; tick(F);
    chk("R3 later fault overwrites", 32'(ch(2)), 0);
    scg[2] = 0;

    clr = 1; tick(1); clr = 0;
    chk("R5 clear codes", 32'(diag), 32'hFFFF);
    chk("R5 clear any", 32'(f_any), 0);

    scb[1] = 1; tick(F);
    chk("R8 fixed channel code", 32'(ch(1)), 2);
    chk("R8 fixed channel off", 32'(off[1]), 1);
    scb[1] = 0; tick(2);
    chk("R4 off latched", 32'(off[1]), 1);

    scb[6] = 1; scb[7] = 1; cfg[7] = 1; tick(F);
    chk("R9 keep-on channel code", 32'(ch(6)), 2);
    chk("R9 keep-on channel off", 32'(off[6]), 0);
    chk("R9 shutdown channel off", 32'(off[7]), 1);
    scb[6] = 0; scb[7] = 0;

    ot[3] = 1; tick(F);
    chk("R6 ot flag", 32'(ot_any), 1);
    chk("R8 no off on ot", 32'(off[3]), 0);
    ot[3] = 0;

    clr = 1; tick(1); clr = 0;
    chk("R5 clear releases off", 32'(off), 0);
    chk("R5 clear ot flag", 32'(ot_any), 0);

    uv = 1; ol[4] = 1; tick(F+2);
    chk("R7 nothing under uv", 32'(ch(4)), 3);
    uv = 0; tick(F-1);
    chk("R7 filter restarted", 32'(ch(4)), 3);
    tick(1);
    chk("R7 stored after uv", 32'(ch(4)), 1);

    clr = 1; tick(1); clr = 0;
    chk("R5 clear wins", 32'(ch(4)), 3);
    tick(1);
    chk("R5 restored next edge", 32'(ch(4)), 1);
    ol[4] = 0;

    ol[5] = 1; ot[5] = 1; tick(F);
    chk("R10 ot over ol", 32'(ch(5)), 2);
    ol[5] = 0; ot[5] = 0;
    scg[0] = 1; scb[0] = 1; tick(F);
    chk("R10 scb over scg", 32'(ch(0)), 2);
    scg[0] = 0; scb[0] = 0;

    rst = 1; tick(2); rst = 0;
    chk("R11 reset again diag", 32'(diag), 32'hFFFF);
    chk("R11 reset again off", 32'(off), 0);

    tick(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule